// File: doc/BRIEF.md
# Two-Channel Program Counter Break Unit

This block watches the address stream of the processor, covering both instruction fetches and data accesses. It holds two independent break channels. Each channel has a compare address, an enable bit, an interrupt enable bit and an access-kind condition. When a valid access matches an enabled channel, that channel's sticky match flag is set. A single interrupt request is shared by both channels, so the handler reads the flag register to learn which channel fired.

A flag clears only when software first reads it as 1 and then writes 0 to it. Fetches that the core will throw away, such as the slot after a jump, call, trap or return, carry a discard qualifier and never match. A match seen while another bus master owns the bus is kept pending and is posted to the flag once the CPU owns the bus again. Out of reset the unit is stopped: it compares nothing and its register port is dead until the stop input is released.

Top module: `pc_break_unit`

## Requirements
- R1: After reset the compare addresses, the control register and both flags read 0, and `irq` is 0.
- R2: While `mod_stop` is 1, register writes have no effect, `reg_rdata` is 0 and no access can set a flag.
- R3: A cycle with `mon_valid`=1, `mon_discard`=0, an enabled channel whose compare address equals `mon_addr` and a satisfied condition sets that channel's flag at the next clock edge. The `mon_kind` encoding is 00 fetch, 01 read, 10 write. The condition field encoding is 00 fetch, 01 read, 10 write, 11 read or write.
- R4: No flag is set when the address differs, the access kind fails the condition, or the channel's enable bit is 0.
- R5: An access with `mon_discard`=1 never sets a flag.
- R6: `irq` is 1 exactly when some channel has both its flag and its interrupt enable set, and it is the same output for both channels.
- R7: A set flag stays set, and `irq` stays asserted, for as long as software does not clear it.
- R8: Writing 0 to a flag that has not been read as 1 since the last write to the flag register leaves it set. Writing 1 never sets or clears a flag.
- R9: Reading the flag register (word 3; bit 0 is channel A, bit 1 is channel B) while a flag is 1 arms its clear. The next write to word 3 clears the flag if the written bit is 0. Any write to word 3 disarms both clears.
- R10: If a match and a valid clear of the same flag fall in the same cycle, the flag remains 1.
- R11: A match while `cpu_owns_bus`=0 does not set the flag. It is held and sets the flag at the first clock edge where `cpu_owns_bus`=1.
- R12: The register map uses word 0 for the A address, word 1 for the B address and word 2 for control. In the control word, channel A uses bit 0 enable, bit 1 irq enable and bits 3:2 condition, and channel B uses bits 4, 5 and 7:6. Unimplemented bits and words 4 to 7 read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mod_stop | input | 1 | 1 halts the unit and blocks register access |
| reg_cs | input | 1 | Register access strobe |
| reg_we | input | 1 | 1 write, 0 read |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, same cycle |
| mon_valid | input | 1 | Monitored access present |
| mon_addr | input | 24 | Monitored access address |
| mon_kind | input | 2 | 00 fetch, 01 read, 10 write |
| mon_discard | input | 1 | Fetch will not execute |
| cpu_owns_bus | input | 1 | 1 when the CPU is bus master |
| irq | output | 1 | Shared break request |

## Verification
A corrupted flag shows on `irq` in the very next cycle whenever the matching interrupt enable is set, and it shows on a read of word 3 otherwise. A wrongly armed or stale clear latch only shows when the next write of 0 to word 3 arrives, so the bench interleaves reads and writes to catch a clear that happens too early or too late. A lost pending match only shows once bus mastership returns, so the bench checks the cycle before that return as well as the cycle after it.

// File: rtl/pc_break_unit.sv
module pc_break_unit #(
  parameter int AW  = 24,
  parameter int DW  = 32,
  parameter int RAW = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           mod_stop,
  input  logic           reg_cs,
  input  logic           reg_we,
  input  logic [RAW-1:0] reg_addr,
  input  logic [DW-1:0]  reg_wdata,
  output logic [DW-1:0]  reg_rdata,
  input  logic           mon_valid,
  input  logic [AW-1:0]  mon_addr,
  input  logic [1:0]     mon_kind,
  input  logic           mon_discard,
  input  logic           cpu_owns_bus,
  output logic           irq
);
  localparam int NCH = 2;
  localparam logic [RAW-1:0] W_ADDR_A = RAW'(0);
  localparam logic [RAW-1:0] W_ADDR_B = RAW'(1);
  localparam logic [RAW-1:0] W_CTRL   = RAW'(2);
  localparam logic [RAW-1:0] W_FLAG   = RAW'(3);

  logic [AW-1:0]    cmp [NCH];
  logic [4*NCH-1:0] ctrl;
  logic [NCH-1:0]   flag, pend, armed, hit, en, ie, set_now, clr;

  wire acc_ok = reg_cs && !mod_stop;
  wire wr     = acc_ok && reg_we;
  wire rd     = acc_ok && !reg_we;
  wire live   = mon_valid && !mon_discard && !mod_stop;
  wire post   = cpu_owns_bus && !mod_stop;

  function automatic logic kind_ok(input logic [1:0] c, input logic [1:0] k);
    case (c)
      2'b00:   return k == 2'b00;
      2'b01:   return k == 2'b01;
      2'b10:   return k == 2'b10;
      default: return (k == 2'b01) || (k == 2'b10);
    endcase
  endfunction

  always_comb begin
    for (int i = 0; i < NCH; i++) begin
      en[i]  = ctrl[4*i];
      ie[i]  = ctrl[4*i+1];
      hit[i] = live && en[i] && (mon_addr == cmp[i]) && kind_ok(ctrl[4*i+2 +: 2], mon_kind);
    end
  end

  assign set_now = (hit | pend) & {NCH{post}};
  assign clr     = {NCH{wr && reg_addr == W_FLAG}} & armed & ~reg_wdata[NCH-1:0];
  assign irq     = |(flag & ie);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp[0] <= '0;
      cmp[1] <= '0;
      ctrl   <= '0;
      flag   <= '0;
      pend   <= '0;
      armed  <= '0;
    end else begin
      flag <= (flag & ~clr) | set_now;
      if (!mod_stop) pend <= cpu_owns_bus ? '0 : (pend | hit);
      if (wr) begin
        case (reg_addr)
          W_ADDR_A: cmp[0] <= reg_wdata[AW-1:0];
          W_ADDR_B: cmp[1] <= reg_wdata[AW-1:0];
          W_CTRL:   ctrl   <= reg_wdata[4*NCH-1:0];
          default:  ;
        endcase
      end
      if (wr && reg_addr == W_FLAG)      armed <= '0;
      else if (rd && reg_addr == W_FLAG) armed <= armed | flag;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (rd) begin
      case (reg_addr)
        W_ADDR_A: reg_rdata[AW-1:0]    = cmp[0];
        W_ADDR_B: reg_rdata[AW-1:0]    = cmp[1];
        W_CTRL:   reg_rdata[4*NCH-1:0] = ctrl;
        W_FLAG:   reg_rdata[NCH-1:0]   = flag;
        default:  ;
      endcase
    end
  end
endmodule

// File: rtl/pc_break_unit_chk.sv
module pc_break_unit_chk #(
  parameter int DW  = 32,
  parameter int RAW = 3
) (
  input logic           clk,
  input logic           rst_n,
  input logic           mod_stop,
  input logic           reg_cs,
  input logic           reg_we,
  input logic [RAW-1:0] reg_addr,
  input logic [DW-1:0]  reg_rdata,
  input logic           cpu_owns_bus,
  input logic [1:0]     flag
);
  wire flag_wr = reg_cs && reg_we && !mod_stop && (reg_addr == RAW'(3));

  a_r2_stop_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    mod_stop |=> $stable(flag));

  a_r2_stop_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    mod_stop |-> reg_rdata == '0);

  a_r7_flag_a_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flag[0] && !flag_wr) |=> flag[0]);

  a_r7_flag_b_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flag[1] && !flag_wr) |=> flag[1]);

  a_r11_no_set_off_bus: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_owns_bus |=> ((flag & ~$past(flag)) == 2'b00));

  a_r12_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_cs && !reg_we && reg_addr > RAW'(3)) |-> reg_rdata == '0);
endmodule

bind pc_break_unit pc_break_unit_chk #(.DW(DW), .RAW(RAW)) chk_i (
  .clk(clk), .rst_n(rst_n), .mod_stop(mod_stop), .reg_cs(reg_cs),
  .reg_we(reg_we), .reg_addr(reg_addr), .reg_rdata(reg_rdata),
  .cpu_owns_bus(cpu_owns_bus), .flag(flag)
);

// File: tb/pc_break_unit_tb_top.sv
`timescale 1ns/1ps
module pc_break_unit_tb_top;
  logic        clk = 0, rst_n = 0, mod_stop = 1;
  logic        reg_cs = 0, reg_we = 0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        mon_valid = 0, mon_discard = 0, cpu_owns_bus = 1, irq;
  logic [23:0] mon_addr = '0;
  logic [1:0]  mon_kind = '0;
  int checks = 0, errors = 0;
  bit done = 0;

  typedef struct { bit is_irq; logic [31:0] exp; string tag; } item_t;
  item_t q[$];

  always #2.5 clk = ~clk;

  pc_break_unit dut_i (.*);

  always @(negedge clk) begin
    item_t it;
    logic [31:0] got;
    if (q.size() > 0) begin
      it  = q.pop_front();
      got = it.is_irq ? {31'b0, irq} : reg_rdata;
      checks++;
      if (got !== it.exp) begin
        errors++;
        $display("FAIL %s: got %h expected %h", it.tag, got, it.exp);
      end
    end
  end

  task automatic quiet();
    reg_cs = 0; reg_we = 0; mon_valid = 0; mon_discard = 0;
  endtask
  task automatic idle(int n = 1);
    repeat (n) begin @(posedge clk); #1; quiet(); end
  endtask
  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(posedge clk); #1; quiet(); reg_cs = 1; reg_we = 1; reg_addr = a; reg_wdata = d;
  endtask
  task automatic rd(input logic [2:0] a, input logic [31:0] e, input string tag);
    @(posedge clk); #1; quiet(); reg_cs = 1; reg_addr = a;
    q.push_back('{0, e, tag});
  endtask
  task automatic chk_irq(input bit e, input string tag);
    @(posedge clk); #1; quiet();
    q.push_back('{1, {31'b0, e}, tag});
  endtask
  task automatic acc(input logic [23:0] a, input logic [1:0] k, input bit disc);
    @(posedge clk); #1; quiet(); mon_valid = 1; mon_addr = a; mon_kind = k; mon_discard = disc;
  endtask
  task automatic set_stop(input bit v);
    @(posedge clk); #1; quiet(); mod_stop = v;
  endtask
  task automatic set_bus(input bit v);
    @(posedge clk); #1; quiet(); cpu_owns_bus = v;
  endtask

  initial begin
    #20000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R2: stopped unit ignores writes and reads zero
    wr(3'd0, 32'h0012_3456);
    wr(3'd2, 32'h0000_0003);
    rd(3'd0, 32'h0, "R2 read while stopped");
    set_stop(0);
    // R1: reset state
    rd(3'd0, 32'h0, "R1 addr A after reset (R2 write dropped)");
    rd(3'd2, 32'h0, "R1 ctrl after reset");
    rd(3'd3, 32'h0, "R1 flags after reset");
    chk_irq(0, "R1 irq after reset");
    // R12: register map
    wr(3'd0, 32'hAB00_1000);
    wr(3'd1, 32'h0000_2000);
    wr(3'd2, 32'hFFFF_FF93);
    rd(3'd0, 32'h0000_1000, "R12 addr A upper bits zero");
    rd(3'd1, 32'h0000_2000, "R12 addr B");
    rd(3'd2, 32'h0000_0093, "R12 ctrl width");
    rd(3'd5, 32'h0, "R12 unmapped word");
    // R4 / R5
    acc(24'h1000, 2'b01, 0);
    acc(24'h1004, 2'b00, 0);
    acc(24'h1000, 2'b00, 1);
    rd(3'd3, 32'h0, "R4 R5 no match");
    chk_irq(0, "R5 irq after discarded fetch");
    // R3 / R6 / R7 / R8
    acc(24'h1000, 2'b00, 0);
    chk_irq(1, "R3 R6 fetch match raises irq");
    idle(4);
    chk_irq(1, "R7 irq held");
    wr(3'd3, 32'h0);
    rd(3'd3, 32'h1, "R8 write 0 without read keeps flag");
    wr(3'd3, 32'h1);
    wr(3'd3, 32'h0);
    rd(3'd3, 32'h1, "R9 write disarms clear");
    wr(3'd3, 32'h0);
    rd(3'd3, 32'h0, "R9 read then write 0 clears");
    chk_irq(0, "R9 irq drops");
    // channel B, write condition, irq enable
    acc(24'h2000, 2'b01, 0);
    rd(3'd3, 32'h0, "R4 B read fails write condition");
    acc(24'h2000, 2'b10, 0);
    rd(3'd3, 32'h2, "R3 B write match");
    chk_irq(0, "R6 B flag without irq enable");
    wr(3'd2, 32'h0000_00B3);
    chk_irq(1, "R6 B enable shares irq");
    wr(3'd2, 32'h0000_00B2);
    acc(24'h1000, 2'b00, 0);
    rd(3'd3, 32'h2, "R4 disabled channel A");
    wr(3'd3, 32'h0);
    rd(3'd3, 32'h0, "R9 B cleared");
    wr(3'd2, 32'h0000_00F3);
    acc(24'h2000, 2'b01, 0);
    rd(3'd3, 32'h2, "R3 read-or-write condition");
    // R10: match and clear in the same cycle
    @(posedge clk); #1; quiet();
    reg_cs = 1; reg_we = 1; reg_addr = 3'd3; reg_wdata = 32'h0;
    mon_valid = 1; mon_addr = 24'h2000; mon_kind = 2'b10;
    rd(3'd3, 32'h2, "R10 set wins over clear");
    wr(3'd3, 32'h0);
    rd(3'd3, 32'h0, "R10 later clear works");
    // R11: deferred while another master owns bus
    set_bus(0);
    acc(24'h1000, 2'b00, 0);
    idle(3);
    rd(3'd3, 32'h0, "R11 no flag while off bus");
    chk_irq(0, "R11 no irq while off bus");
    set_bus(1);
    rd(3'd3, 32'h1, "R11 pending posted on return");
    chk_irq(1, "R11 irq after return");
    wr(3'd3, 32'h0);
    rd(3'd3, 32'h0, "R9 A cleared again");
    // R2: no matching while stopped
    set_stop(1);
    acc(24'h1000, 2'b00, 0);
    set_stop(0);
    rd(3'd3, 32'h0, "R2 no match while stopped");
    rd(3'd2, 32'h0000_00F3, "R2 registers kept through stop");
    idle(2);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule